// File: doc/BRIEF.md
# Passive LCD Frame Timing Generator

This block produces the timing strobes that drive a passive grayscale LCD panel: a per-pixel clock enable, a line pulse that closes every line, a frame marker covering the first line of each frame, the alternating AC-bias signal the panel needs to avoid DC stress, and a strobe for every 128-bit word of display memory that the scanned pixels consume. All geometry comes from one 32-bit control word. The word holds the frame buffer size in 128-bit words, the line length in groups of 16 pixels, the divider that sets the pixel rate from the reference clock, the number of line pulses per AC-bias half period, and the pixel depth.

Software loads the control word while the generator is stopped, then raises the enable. The number of lines per frame is not programmed directly. The block derives it from the buffer size, the line length and the pixel depth, and rounds down to whole lines. Lowering the enable stops the generator at once and clears its position, so the next enable starts a fresh frame. Fetching memory and formatting pixel data are left to neighbouring blocks, which pace themselves on the strobes.

Top module: `lcd_frame_timer`

## Requirements
- R1: With divider field D in control bits 24:19, `pix_en` pulses once every D+1 reference clock cycles during the visible part of a line.
- R2: With line field L in control bits 18:13, each line has (L+1)*16 `pix_en` pulses. These are followed by `line_pulse`, held high for one pixel period (D+1 cycles), and no `pix_en` occurs while it is high.
- R3: With size field S in control bits 12:0, a frame has floor((S+1)*128 / ((L+1)*16*bpp)) lines, with a minimum of one. `frame_pulse` is high during exactly the first line of each frame, including that line's line pulse.
- R4: The depth code in control bits 31:30 selects bits per pixel: 00 selects 1, 01 selects 2, and 10 or 11 select 4.
- R5: With AC field A in control bits 29:25, `ac_bias` starts low on enable and inverts at the end of every (A+1)-th line pulse, at the same time as the line pulse falls.
- R6: `fetch_req` pulses together with the `pix_en` that completes each 128 bits of pixel data. The bit count restarts at every frame, so a frame gives floor(lines*(L+1)*16*bpp/128) requests.
- R7: A write to the control word is dropped, not deferred, while `en` is high or the generator is still running. This includes the cycle in which `en` has just fallen.
- R8: When `en` is low, every output is low from the next cycle on. The next enable restarts at pixel 0 of line 0 of a new frame.
- R9: After reset the control word describes 640 pixels by 240 lines at 4 bits per pixel, divider 0, AC field 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Run enable for the generator |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word value |
| pix_en | output | 1 | One-cycle strobe per visible pixel |
| line_pulse | output | 1 | High for one pixel period after the last pixel of a line |
| frame_pulse | output | 1 | High throughout the first line of each frame |
| ac_bias | output | 1 | AC-bias signal, inverting every A+1 lines |
| fetch_req | output | 1 | Strobe per 128 bits of pixel data consumed |

## Verification
A wrong pixel divider or line counter shows in the first line: the spacing of `pix_en` or the number of pixels before the first `line_pulse` is off within a few tens of cycles of enable. A fault in the remaining-budget register or the frame wrap shows only when `frame_pulse` returns, so the line count and the fetch count are checked over one whole frame for every depth code. This includes a geometry where the buffer is not a whole number of lines. A stuck AC divider shows at the first `ac_bias` edge. A control word that is wrongly accepted while running only shows after the generator is disabled and enabled again, so that case is re-measured after a restart.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

  // control word field widths
  localparam int SIZE_W  = 13;
  localparam int LLEN_W  = 6;
  localparam int PDIV_W  = 6;
  localparam int AC_W    = 5;
  localparam int DEPTH_W = 2;
  localparam int WORD_W  = SIZE_W + LLEN_W + PDIV_W + AC_W + DEPTH_W;

  // derived widths
  localparam int WORD_BITS_LOG = 7;                        // 128-bit memory words
  localparam int PIXGRP_LOG    = 4;                        // 16-pixel line groups
  localparam int X_W   = LLEN_W + PIXGRP_LOG + 1;          // pixels per line
  localparam int LB_W  = X_W + 2;                          // bits per line (<= 4 bpp)
  localparam int TOT_W = SIZE_W + WORD_BITS_LOG + 1;       // bits per frame buffer
  localparam int BPP_W = 3;                                // 1, 2 or 4
  localparam int ACC_W = WORD_BITS_LOG;

  typedef struct packed {
    logic [DEPTH_W-1:0] depth;
    logic [AC_W-1:0]    ac;
    logic [PDIV_W-1:0]  pdiv;
    logic [LLEN_W-1:0]  llen;
    logic [SIZE_W-1:0]  size;
  } lcd_word_t;

  function automatic logic [1:0] depth_shift(input logic [DEPTH_W-1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/lcd_cfg_reg.sv
module lcd_cfg_reg
  import lcd_tim_pkg::*;
#(
  parameter lcd_word_t RST_WORD = '0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      busy,
  input  logic      we,
  input  lcd_word_t wdata,
  output lcd_word_t word_q
);

  lcd_word_t word_d;

  always_comb begin
    word_d = word_q;
    if (we && !busy) word_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= RST_WORD;
    else        word_q <= word_d;
  end

endmodule

// File: rtl/lcd_pix_div.sv
module lcd_pix_div #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lcd_line_seq.sv
module lcd_line_seq #(
  parameter int X_W   = 11,
  parameter int ACC_W = 7,
  parameter int BPP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [X_W-1:0]   line_pix,
  input  logic [BPP_W-1:0] bpp,
  input  logic             restart,
  output logic             pix_en,
  output logic             line_end,
  output logic             line_pulse,
  output logic             fetch_req
);

  logic [X_W-1:0]   xcnt_q, xcnt_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   acc_sum;
  logic             visible;

  // slot line_pix is the line-pulse slot after the last pixel
  assign visible    = (xcnt_q != line_pix);
  assign pix_en     = tick && visible;
  assign line_end   = tick && !visible;
  assign line_pulse = run && !visible;

  assign acc_sum   = {1'b0, acc_q} + (ACC_W+1)'(bpp);
  assign fetch_req = pix_en && acc_sum[ACC_W];

  always_comb begin
    xcnt_d = xcnt_q;
    if (!run)          xcnt_d = '0;
    else if (line_end) xcnt_d = '0;
    else if (tick)     xcnt_d = xcnt_q + 1'b1;
  end

  always_comb begin
    acc_d = acc_q;
    if (!run)                     acc_d = '0;
    else if (line_end && restart) acc_d = '0;
    else if (pix_en)              acc_d = acc_sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcnt_q <= '0;
      acc_q  <= '0;
    end else begin
      xcnt_q <= xcnt_d;
      acc_q  <= acc_d;
    end
  end

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq #(
  parameter int TOT_W = 21,
  parameter int LB_W  = 13,
  parameter int AC_W  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            line_end,
  input  logic [TOT_W-1:0] total_bits,
  input  logic [LB_W-1:0]  line_bits,
  input  logic [AC_W-1:0]  ac_div,
  output logic            restart,
  output logic            first_line,
  output logic            m_out
);

  logic [TOT_W-1:0] rem_q, rem_d, start_rem, lb_ext;
  logic             first_d;
  logic [AC_W-1:0]  acnt_q, acnt_d;
  logic             m_d;
  logic             ac_flip;

  assign lb_ext    = TOT_W'(line_bits);
  // budget left after line 0; a buffer smaller than one line still gives one line
  assign start_rem = (total_bits >= lb_ext) ? (total_bits - lb_ext) : '0;
  assign restart   = line_end && (rem_q < lb_ext);
  assign ac_flip   = line_end && (acnt_q == ac_div);

  always_comb begin
    rem_d   = rem_q;
    first_d = first_line;
    if (!run) begin
      rem_d   = start_rem;
      first_d = 1'b1;
    end else if (line_end) begin
      rem_d   = restart ? start_rem : (rem_q - lb_ext);
      first_d = restart;
    end
  end

  always_comb begin
    acnt_d = acnt_q;
    m_d    = m_out;
    if (!run) begin
      acnt_d = '0;
      m_d    = 1'b0;
    end else if (line_end) begin
      acnt_d = ac_flip ? '0 : (acnt_q + 1'b1);
      if (ac_flip) m_d = !m_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q      <= '0;
      first_line <= 1'b1;
      acnt_q     <= '0;
      m_out      <= 1'b0;
    end else begin
      rem_q      <= rem_d;
      first_line <= first_d;
      acnt_q     <= acnt_d;
      m_out      <= m_d;
    end
  end

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcd_tim_pkg::*;
#(
  parameter int DEF_XRES = 640,
  parameter int DEF_YRES = 240,
  parameter int DEF_BPP  = 4,
  parameter int DEF_PDIV = 0,
  parameter int DEF_AC   = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic        pix_en,
  output logic        line_pulse,
  output logic        frame_pulse,
  output logic        ac_bias,
  output logic        fetch_req
);

  localparam int DEF_SIZE  = DEF_XRES * DEF_YRES * DEF_BPP / 128 - 1;
  localparam int DEF_LLEN  = DEF_XRES / 16 - 1;
  localparam int DEF_DCODE = (DEF_BPP == 1) ? 0 : (DEF_BPP == 2) ? 1 : 3;
  localparam lcd_word_t DEF_WORD = {
    DEPTH_W'(DEF_DCODE), AC_W'(DEF_AC), PDIV_W'(DEF_PDIV),
    LLEN_W'(DEF_LLEN), SIZE_W'(DEF_SIZE)
  };

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  logic run;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) run <= 1'b0;
    else        run <= en;
  end

  lcd_word_t cfg_q;

  lcd_cfg_reg #(.RST_WORD(DEF_WORD)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_s),
    .busy   (en || run),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .word_q (cfg_q)
  );

  // geometry derived from the control word
  logic [1:0]       dshift;
  logic [BPP_W-1:0] bpp;
  logic [X_W-1:0]   line_pix;
  logic [LB_W-1:0]  line_bits;
  logic [TOT_W-1:0] total_bits;

  assign dshift     = depth_shift(cfg_q.depth);
  assign bpp        = BPP_W'(1) << dshift;
  assign line_pix   = (X_W'(cfg_q.llen) + X_W'(1)) << PIXGRP_LOG;
  assign line_bits  = LB_W'(line_pix) << dshift;
  assign total_bits = (TOT_W'(cfg_q.size) + TOT_W'(1)) << WORD_BITS_LOG;

  logic tick, line_end, restart, first_line, m_int;

  lcd_pix_div #(.W(PDIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_s),
    .run   (run),
    .div   (cfg_q.pdiv),
    .tick  (tick)
  );

  lcd_line_seq #(.X_W(X_W), .ACC_W(ACC_W), .BPP_W(BPP_W)) u_line (
    .clk        (clk),
    .rst_n      (rst_s),
    .run        (run),
    .tick       (tick),
    .line_pix   (line_pix),
    .bpp        (bpp),
    .restart    (restart),
    .pix_en     (pix_en),
    .line_end   (line_end),
    .line_pulse (line_pulse),
    .fetch_req  (fetch_req)
  );

  lcd_frame_seq #(.TOT_W(TOT_W), .LB_W(LB_W), .AC_W(AC_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_s),
    .run        (run),
    .line_end   (line_end),
    .total_bits (total_bits),
    .line_bits  (line_bits),
    .ac_div     (cfg_q.ac),
    .restart    (restart),
    .first_line (first_line),
    .m_out      (m_int)
  );

  assign frame_pulse = run && first_line;
  assign ac_bias     = run && m_int;

endmodule

// File: rtl/lcd_frame_timer_chk.sv
module lcd_frame_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        run,
  input logic [31:0] cfg_word,
  input logic        pix_en,
  input logic        line_pulse,
  input logic        frame_pulse,
  input logic        ac_bias,
  input logic        fetch_req
);

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en || run) |=> $stable(cfg_word));

  assert_quiet_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(pix_en || line_pulse || frame_pulse || ac_bias || fetch_req));

  assert_no_pix_in_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_en && line_pulse));

  assert_fetch_on_pix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> pix_en);

  assert_ac_at_line_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (ac_bias != $past(ac_bias))) |-> ($past(line_pulse) && !line_pulse));

  assert_frame_after_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_pulse) && $past(run)) |-> $past(line_pulse));

endmodule

bind lcd_frame_timer lcd_frame_timer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .run         (run),
  .cfg_word    (cfg_q),
  .pix_en      (pix_en),
  .line_pulse  (line_pulse),
  .frame_pulse (frame_pulse),
  .ac_bias     (ac_bias),
  .fetch_req   (fetch_req)
);

// File: tb/sim_lcd_frame_timer.sv
module sim_lcd_frame_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        pix_en, line_pulse, frame_pulse, ac_bias, fetch_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;   // 250 MHz

  lcd_frame_timer u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pix_en(pix_en), .line_pulse(line_pulse), .frame_pulse(frame_pulse),
    .ac_bias(ac_bias), .fetch_req(fetch_req)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  // depth code 31:30, AC 29:25, divider 24:19, line groups 18:13, size 12:0
  function automatic logic [31:0] mk_word(input int code, input int ac, input int dv,
                                          input int ll, input int sz);
    return {code[1:0], ac[4:0], dv[5:0], ll[5:0], sz[12:0]};
  endfunction

  task automatic write_cfg(input logic [31:0] w);
    cfg_we    = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  function automatic int outs_or();
    return int'(pix_en | line_pulse | frame_pulse | ac_bias | fetch_req);
  endfunction

  // enable and measure one frame plus the first AC-bias edge
  task automatic measure(input string tag, input int e_pix, input int e_gap,
                         input int e_lpw, input int e_lines, input int e_fetch,
                         input int e_ac);
    int cyc = 0, last_pix = -1, gap = -1, pix1 = 0, lpw = 0;
    int lines = 0, fetch = 0, flp = 0, falls = 0, ac_at = -1;
    bit lp_seen = 0, lp_done = 0, frame_done = 0;
    logic p_lp = 1'b0, p_fp = 1'b1, p_ac = 1'b0;
    en = 1'b1;
    while (!(frame_done && ac_at >= 0) && cyc < 170000) begin
      @(negedge clk);
      cyc++;
      if (pix_en) begin
        if (last_pix >= 0 && gap < 0) gap = cyc - last_pix;
        last_pix = cyc;
        if (!lp_seen) pix1++;
      end
      if (line_pulse) begin
        lp_seen = 1;
        if (!lp_done) lpw++;
      end else if (lp_seen) lp_done = 1;
      if (!frame_done) begin
        if (line_pulse && !p_lp) begin
          lines++;
          if (frame_pulse) flp++;
        end
        if (fetch_req) fetch++;
        if (frame_pulse && !p_fp) frame_done = 1;
      end
      if (!line_pulse && p_lp) falls++;
      if (ac_at < 0 && ac_bias && !p_ac) ac_at = falls;
      p_lp = line_pulse; p_fp = frame_pulse; p_ac = ac_bias;
    end
    chk({tag, " R1 pixel spacing"}, gap, e_gap);
    chk({tag, " R2 pixels per line"}, pix1, e_pix);
    chk({tag, " R2 line pulse width"}, lpw, e_lpw);
    chk({tag, " R3 lines per frame"}, lines, e_lines);
    chk({tag, " R3 line pulses under frame marker"}, flp, 1);
    chk({tag, " R6 fetches per frame"}, fetch, e_fetch);
    chk({tag, " R5 lines to first AC edge"}, ac_at, e_ac);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R8 outputs low after reset", outs_or(), 0);
  endtask

  task automatic t_default();
    // R9: 640 px, 240 lines, 4 bpp, divider 0, AC 13
    measure("R9 default", 640, 1, 1, 240, 4800, 14);
  endtask

  task automatic t_geom_a();
    // R4 code 10 = 4 bpp: 5 words, 16 px lines -> 10 lines, 5 fetches
    write_cfg(mk_word(2, 2, 1, 0, 4));
    measure("A 4bpp code10", 16, 2, 2, 10, 5, 3);
  endtask

  task automatic t_geom_b();
    // R4 code 00 = 1 bpp: 3 words, 32 px lines -> 12 lines, 3 fetches
    write_cfg(mk_word(0, 0, 3, 1, 2));
    measure("B 1bpp code00", 32, 4, 4, 12, 3, 1);
  endtask

  task automatic t_geom_c();
    // R4 code 01 = 2 bpp: 256 bits, 96-bit lines -> floor 2 lines, 1 fetch
    write_cfg(mk_word(1, 4, 0, 2, 1));
    measure("C 2bpp partial", 48, 1, 1, 2, 1, 5);
  endtask

  task automatic t_geom_d();
    // R4 code 11 = 4 bpp: 8 words, 128-bit lines -> 8 lines, 8 fetches
    write_cfg(mk_word(3, 6, 2, 1, 7));
    measure("D 4bpp code11", 32, 3, 3, 8, 8, 7);
  endtask

  task automatic t_write_ignored();
    write_cfg(mk_word(2, 2, 1, 0, 4));
    en = 1'b1;
    repeat (20) @(negedge clk);
    // R7: write while enabled
    write_cfg(mk_word(0, 0, 3, 1, 2));
    repeat (5) @(negedge clk);
    // R7: write in the cycle en falls
    en = 1'b0;
    write_cfg(mk_word(1, 4, 0, 2, 1));
    @(negedge clk);
    measure("R7 ignored writes", 16, 2, 2, 10, 5, 3);
  endtask

  task automatic t_disable();
    en = 1'b1;
    repeat (37) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R8 outputs low one cycle after disable", outs_or(), 0);
    repeat (4) @(negedge clk);
    chk("R8 outputs stay low while disabled", outs_or(), 0);
    measure("R8 restart", 16, 2, 2, 10, 5, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_default();
    t_geom_a();
    t_geom_b();
    t_geom_c();
    t_geom_d();
    t_write_ignored();
    t_disable();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule